// File: doc/BRIEF.md
# Dual Clock Output Selector

This block drives one clock output from either of two free-running sources. The fast source is produced inside the block by dividing a crystal reference clock by an even parameterised ratio; the slow source is a low-power RC clock of roughly 32 kHz supplied from outside. A wake request picks the fast source and its absence picks the slow one. A crystal-ready flag tells the block when the divided crystal clock may be used. An output-disable control parks the output low.

Each source has its own gating leg. A leg brings its request in through a short synchronizer clocked by its own source, and it changes its gate enable only on that source's falling edge. The two legs are cross-coupled: a leg may claim the output only after the other leg's enable has been seen low in its own domain. The output is the OR of the two gated clocks. A handover therefore always passes through exactly one stretched low phase, and no high or low phase is ever shorter than half a fast period. The wake request must stay stable until a handover has completed.

Top module: `clkout_sel`

## Requirements
- R1: While reset is asserted the output is low. After reset is released with the wake request low and the disable control low, the output carries the slow clock.
- R2: With the wake request high and crystal-ready high, the output carries the crystal clock divided by FAST_DIV (default 10), high for exactly half of each period.
- R3: While the wake request is high and crystal-ready is low, the output stays low with no edges. The fast leg claims the output only while crystal-ready is high, and the fast clock appears after crystal-ready rises.
- R4: With the disable control high, both legs release, and the output settles low and stays low. When the control returns low, the selected clock reappears.
- R5: Every high phase and every low phase of the output lasts at least half a fast period.
- R6: Each handover produces exactly one low phase whose length matches neither nominal half period. That phase is longer than half a fast period.
- R7: The two gate enables are never high at the same time.
- R8: Each gate enable changes only while its own source clock is low.
- R9: With both sources running, the time from a change of the wake request to the first rising edge of the new source on the output is at most three fast periods plus three slow periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal reference clock, divided internally to form the fast source |
| rc_clk | input | 1 | Free-running slow RC clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fast_req | input | 1 | Wake request: 1 selects the fast source, 0 selects the slow source |
| xtal_ready | input | 1 | Crystal has finished starting and the fast source may be used |
| out_disable | input | 1 | 1 parks the output low through a clean release of both legs |
| clk_out | output | 1 | Selected, glitch-free output clock |

## Verification
The checker samples on the crystal clock and checks on every cycle that the two enables are never high together, that each enable changes only while its own source is low, that the fast leg claims only while crystal-ready is high, and that no output phase is cut to a single sample. Only the bench's scenarios can show the effects that span a whole handover. These are the count of stretched low phases per switch, the latency bound measured in real time against both periods, the exact output periods and duty cycle after each switch, and the quiet, edge-free output while the crystal is not ready or the output is disabled.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
    // Number of clock sources and their leg indices.
    localparam int unsigned NUM_SRC  = 2;
    localparam int unsigned SRC_FAST = 0;
    localparam int unsigned SRC_SLOW = 1;
endpackage

// File: rtl/clkout_div.sv
`timescale 1ns/1ps
// Even divider of the crystal reference; output has 50 % duty.
module clkout_div #(
    parameter int unsigned FAST_DIV = 10
) (
    input  logic xtal_clk,
    input  logic rst_ni,
    output logic fast_clk
);
    localparam int unsigned HALF = FAST_DIV / 2;
    localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          clk;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == CW'(HALF - 1)) begin
            div_d.cnt = '0;
            div_d.clk = ~div_q.clk;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge xtal_clk or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    assign fast_clk = div_q.clk;
endmodule

// File: rtl/clkout_leg.sv
`timescale 1ns/1ps
// One gating leg: request synchronized on rising edges of the leg's own
// clock, enable updated on its falling edge so it only moves while low.
module clkout_leg #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic want_i,
    output logic en_o
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   en_d,   en_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], want_i};
        en_d   = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= en_d;
    end

    assign en_o = en_q;
endmodule

// File: rtl/clkout_sel.sv
`timescale 1ns/1ps
module clkout_sel
    import clkout_pkg::*;
#(
    parameter int unsigned FAST_DIV    = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic xtal_clk,
    input  logic rc_clk,
    input  logic rst_ni,
    input  logic fast_req,
    input  logic xtal_ready,
    input  logic out_disable,
    output logic clk_out
);
    logic               fast_clk;
    logic [NUM_SRC-1:0] leg_clk;
    logic [NUM_SRC-1:0] leg_want;
    logic [NUM_SRC-1:0] leg_en;

    clkout_div #(.FAST_DIV(FAST_DIV)) u_div (
        .xtal_clk (xtal_clk),
        .rst_ni   (rst_ni),
        .fast_clk (fast_clk)
    );

    // Cross-coupled claim conditions: a leg may claim only once the other
    // leg's enable is low.
    always_comb begin
        leg_clk[SRC_FAST]  = fast_clk;
        leg_clk[SRC_SLOW]  = rc_clk;
        leg_want[SRC_FAST] = fast_req & xtal_ready & ~out_disable & ~leg_en[SRC_SLOW];
        leg_want[SRC_SLOW] = ~fast_req & ~out_disable & ~leg_en[SRC_FAST];
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
        clkout_leg #(.SYNC_STAGES(SYNC_STAGES)) u_leg (
            .clk_i  (leg_clk[i]),
            .rst_ni (rst_ni),
            .want_i (leg_want[i]),
            .en_o   (leg_en[i])
        );
    end

    assign clk_out = |(leg_clk & leg_en);
endmodule

// File: rtl/clkout_sel_chk.sv
`timescale 1ns/1ps
module clkout_sel_chk #(
    parameter int unsigned FAST_DIV = 10
) (
    input logic xtal_clk,
    input logic rc_clk,
    input logic rst_ni,
    input logic xtal_ready,
    input logic clk_out,
    input logic fast_clk,
    input logic en_fast,
    input logic en_slow
);
    AST_ONE_SOURCE: assert property (@(posedge xtal_clk) disable iff (!rst_ni)
        !(en_fast && en_slow));                                              // R7
    AST_FAST_EN_WHILE_LOW: assert property (@(posedge xtal_clk) disable iff (!rst_ni)
        !$stable(en_fast) |-> !fast_clk);                                    // R8
    AST_SLOW_EN_WHILE_LOW: assert property (@(posedge xtal_clk) disable iff (!rst_ni)
        !$stable(en_slow) |-> !rc_clk);                                      // R8
    AST_CLAIM_NEEDS_READY: assert property (@(posedge xtal_clk) disable iff (!rst_ni)
        $rose(en_fast) |-> xtal_ready);                                      // R3

    if (FAST_DIV >= 4) begin : g_width
        AST_NO_SHORT_HIGH: assert property (@(posedge xtal_clk) disable iff (!rst_ni)
            $rose(clk_out) |=> clk_out);                                     // R5
        AST_NO_SHORT_LOW: assert property (@(posedge xtal_clk) disable iff (!rst_ni)
            $fell(clk_out) |=> !clk_out);                                    // R5
    end
endmodule

bind clkout_sel clkout_sel_chk #(.FAST_DIV(FAST_DIV)) u_chk (
    .xtal_clk   (xtal_clk),
    .rc_clk     (rc_clk),
    .rst_ni     (rst_ni),
    .xtal_ready (xtal_ready),
    .clk_out    (clk_out),
    .fast_clk   (fast_clk),
    .en_fast    (leg_en[0]),
    .en_slow    (leg_en[1])
);

// File: tb/clkout_sel_test.sv
`timescale 1ns/1ps
module clkout_sel_test;
    localparam real T_XTAL = 5.0;
    localparam real T_FAST = 50.0;    // 10 crystal periods
    localparam real T_SLOW = 1600.0;
    localparam real TOL    = 1.0;

    logic xtal_clk = 1'b0;
    logic rc_clk   = 1'b0;
    logic rst_ni   = 1'b0;
    logic fast_req = 1'b0;
    logic xtal_ready = 1'b0;
    logic out_disable = 1'b0;
    logic clk_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // output monitor
    bit  mon_on = 1'b0;
    bit  have_last = 1'b0;
    real t_last = 0.0;
    real t_odd_end = 0.0;
    real min_phase = 1.0e9;
    int  odd_lows = 0;
    int  odd_highs = 0;
    int  edge_cnt = 0;

    clkout_sel uut (
        .xtal_clk    (xtal_clk),
        .rc_clk      (rc_clk),
        .rst_ni      (rst_ni),
        .fast_req    (fast_req),
        .xtal_ready  (xtal_ready),
        .out_disable (out_disable),
        .clk_out     (clk_out)
    );

    initial forever #(T_XTAL / 2.0) xtal_clk = ~xtal_clk;
    initial begin
        #3.0;
        forever #(T_SLOW / 2.0) rc_clk = ~rc_clk;
    end

    function automatic bit near(input real a, input real b);
        return (a - b <= TOL) && (b - a <= TOL);
    endfunction

    always @(clk_out) begin
        real ph;
        ph = $realtime - t_last;
        if (mon_on && have_last) begin
            if (ph < min_phase) min_phase = ph;
            if (!near(ph, T_FAST / 2.0) && !near(ph, T_SLOW / 2.0)) begin
                if (clk_out == 1'b1) begin
                    odd_lows++;
                    t_odd_end = $realtime;
                end else begin
                    odd_highs++;
                end
            end
        end
        t_last = $realtime;
        have_last = 1'b1;
        edge_cnt++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    task automatic measure(output real period, output real high);
        real t0;
        @(posedge clk_out);
        t0 = $realtime;
        @(negedge clk_out);
        high = $realtime - t0;
        @(posedge clk_out);
        period = $realtime - t0;
    endtask

    task automatic t_reset();
        real p, hi;
        int  bad = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge xtal_clk);
            if (clk_out !== 1'b0) bad++;
        end
        check(bad == 0, "R1", "output high during reset", real'(bad), 0.0);
        @(negedge xtal_clk);
        rst_ni = 1'b1;
        mon_on = 1'b1;
        #(4.0 * T_SLOW);
        measure(p, hi);
        check(near(p, T_SLOW), "R1", "slow period after reset", p, T_SLOW);
        check(near(hi, T_SLOW / 2.0), "R1", "slow high time after reset", hi, T_SLOW / 2.0);
    endtask

    task automatic t_switch(input bit to_fast);
        real t_req, p, hi, lim, exp_p;
        string rq;
        lim   = 3.0 * (T_FAST + T_SLOW);
        exp_p = to_fast ? T_FAST : T_SLOW;
        rq    = to_fast ? "R2" : "R1";
        odd_lows = 0;
        odd_highs = 0;
        @(negedge xtal_clk);
        t_req = $realtime;
        fast_req = to_fast;
        #(5.0 * T_SLOW);
        check(odd_lows == 1, "R6", "stretched low phases in switch", real'(odd_lows), 1.0);
        check(odd_highs == 0, "R5 R7 R8", "irregular high phases in switch", real'(odd_highs), 0.0);
        check((t_odd_end - t_req) <= lim, "R9", "switch latency", t_odd_end - t_req, lim);
        measure(p, hi);
        check(near(p, exp_p), rq, "period after switch", p, exp_p);
        check(near(hi, exp_p / 2.0), rq, "high time after switch", hi, exp_p / 2.0);
    endtask

    task automatic t_xtal_wait();
        int  e0;
        real p, hi;
        xtal_ready = 1'b0;
        @(negedge xtal_clk);
        fast_req = 1'b1;
        #(4.0 * T_SLOW);
        e0 = edge_cnt;
        #(3.0 * T_SLOW);
        check(edge_cnt == e0, "R3", "edges while crystal not ready", real'(edge_cnt - e0), 0.0);
        check(clk_out == 1'b0, "R3", "level while crystal not ready", real'(clk_out), 0.0);
        odd_lows = 0;
        @(negedge xtal_clk);
        xtal_ready = 1'b1;
        #(10.0 * T_FAST);
        check(odd_lows == 1, "R3", "one low phase ended by ready", real'(odd_lows), 1.0);
        measure(p, hi);
        check(near(p, T_FAST), "R3", "fast period after ready", p, T_FAST);
    endtask

    task automatic t_disable();
        int  e0;
        real p, hi;
        @(negedge xtal_clk);
        out_disable = 1'b1;
        #(2.0 * T_SLOW);
        e0 = edge_cnt;
        #(3.0 * T_SLOW);
        check(edge_cnt == e0, "R4", "edges while disabled", real'(edge_cnt - e0), 0.0);
        check(clk_out == 1'b0, "R4", "level while disabled", real'(clk_out), 0.0);
        @(negedge xtal_clk);
        out_disable = 1'b0;
        #(20.0 * T_FAST);
        measure(p, hi);
        check(near(p, T_FAST), "R4", "fast period after enable", p, T_FAST);
    endtask

    initial begin
        t_reset();
        t_xtal_wait();
        t_switch(1'b0);
        t_switch(1'b1);
        t_switch(1'b0);
        t_switch(1'b1);
        t_disable();
        check(min_phase >= T_FAST / 2.0 - TOL, "R5", "shortest output phase",
              min_phase, T_FAST / 2.0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(150000.0 * T_XTAL);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule